// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits beside a program sequencer's fetch stage and runs counted loops without spending any instruction slot on a branch or a compare. One setup command, issued before the loop body, delivers the body's first and last addresses, an iteration count and a termination mode. From then on the block compares every fetch address with the innermost loop's last address. At that address it decides in the same cycle whether to send fetch back to the body's first address or let it fall through, and it updates the remaining count on the clock edge that ends that cycle. The fetch stream therefore never stalls at a loop boundary.

Loops nest through a small register stack (four levels by default); only the innermost loop is compared against fetch. A control state machine tracks whether the stack is empty, partly filled or full. Its states are EMPTY, LOOPING and FULL. Its transitions are:
- EMPTY to LOOPING on an accepted push.
- LOOPING to FULL on a push that fills the last level.
- LOOPING to EMPTY on a pop from level one.
- FULL to LOOPING on any pop.

A setup command pushes onto the stack. A loop exit pops it. A setup that arrives while the stack is full is dropped and raises a sticky error.

Top module: `hwloop_seq`

## Requirements
- R1: After reset, `loop_level` is 0, `loop_active` is 0, `overflow_err` is 0 and `loop_remaining` is 0. With no setup pending, `next_pc_override` is 0.
- R2: A setup with a non-zero count, taken while fewer than DEPTH loops are held, pushes a new innermost loop. On the next cycle `loop_level` has risen by one and `loop_remaining` equals the setup count.
- R3: When fetch_pc equals the innermost end address, the remaining count is above 1 and no exit condition holds, `next_pc_override` is 1 and `next_pc` equals that loop's start address in the same cycle.
- R4: A loop-back lowers `loop_remaining` by exactly one on the following cycle.
- R5: When fetch_pc equals the innermost end address and the remaining count is 1, `next_pc_override` is 0 and `next_pc` is end+1. On the next cycle the loop has been popped and `loop_level` is one lower.
- R6: The 2-bit `setup_mode` field is decoded as follows. Value 0 means count only. Value 1 exits early when `cond_flag` is 1 at the end address. Value 2 exits early when `cond_flag` is 0 there. Value 3 behaves as count only. An early exit pops the loop even when the remaining count is above 1.
- R7: A setup with count 0 gives `next_pc_override` = 1 and `next_pc` = setup_end+1 in the same cycle, and leaves the stack unchanged.
- R8: A non-zero-count setup while DEPTH loops are held is ignored: `loop_level` and `loop_remaining` do not change. `overflow_err` becomes 1 and stays 1 until reset.
- R9: Only the innermost loop's end address is compared against fetch. After an inner loop exits, the enclosing loop resumes with its remaining count as it was.
- R10: In a cycle with `setup_valid` = 1, no loop-back or count change happens for the current innermost loop, even when fetch_pc equals its end address.
- R11: When no override applies, `next_pc_override` is 0, `next_pc` is fetch_pc+1, and loop state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_valid | input | 1 | Loop setup command this cycle |
| setup_start | input | AW | First address of the loop body |
| setup_end | input | AW | Last address of the loop body |
| setup_count | input | CW | Iteration count, 0 skips the body |
| setup_mode | input | 2 | Termination mode (see R6) |
| fetch_pc | input | AW | Address being fetched this cycle |
| cond_flag | input | 1 | External condition for modes 1 and 2 |
| next_pc | output | AW | Address to fetch next |
| next_pc_override | output | 1 | 1 when next_pc is not fetch_pc+1 |
| loop_active | output | 1 | At least one loop held |
| loop_level | output | LW | Number of loops held |
| loop_remaining | output | CW | Remaining count of the innermost loop |
| overflow_err | output | 1 | Sticky: setup dropped on a full stack |

## Verification
The fetch-redirect results (`next_pc`, `next_pc_override`) are combinational and due in the same cycle as the fetch address or setup that causes them. The bench drives each stimulus just after a falling edge and samples these outputs one time unit later, before the rising edge. The stack results (`loop_level`, `loop_remaining`, `overflow_err`) change on the rising edge that ends that cycle. The bench checks them one time unit after that edge, against a bench model that it advances at the same point.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_LOOPING = 2'd1,
        ST_FULL    = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        TM_COUNT     = 2'd0,
        TM_UNTIL_HI  = 2'd1,
        TM_UNTIL_LO  = 2'd2,
        TM_COUNT_ALT = 2'd3
    } term_mode_t;

endpackage

// File: rtl/hwl_stack.sv
module hwl_stack #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          dec,
    input  logic [AW-1:0] push_start,
    input  logic [AW-1:0] push_end,
    input  logic [CW-1:0] push_count,
    input  logic [1:0]    push_mode,
    output logic [LW-1:0] level,
    output logic [AW-1:0] top_start,
    output logic [AW-1:0] top_end,
    output logic [CW-1:0] top_count,
    output logic [1:0]    top_mode
);

    logic [AW-1:0] start_q [DEPTH];
    logic [AW-1:0] end_q   [DEPTH];
    logic [CW-1:0] count_q [DEPTH];
    logic [1:0]    mode_q  [DEPTH];
    logic [LW-1:0] lvl_q;
    logic [DEPTH-1:0] slot_top;

    // Stack pointer: number of loops held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (push) begin
            lvl_q <= lvl_q + LW'(1);
        end else if (pop) begin
            lvl_q <= lvl_q - LW'(1);
        end
    end

    // Entry storage: load on push into the free slot, count down the top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                start_q[i] <= '0;
                end_q[i]   <= '0;
                count_q[i] <= '0;
                mode_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && lvl_q == LW'(i)) begin
                    start_q[i] <= push_start;
                    end_q[i]   <= push_end;
                    count_q[i] <= push_count;
                    mode_q[i]  <= push_mode;
                end else if (dec && lvl_q == LW'(i + 1)) begin
                    count_q[i] <= count_q[i] - CW'(1);
                end
            end
        end
    end

    // One-hot marker of the innermost slot.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_top
        assign slot_top[gi] = (lvl_q == LW'(gi + 1));
    end

    always_comb begin
        top_start = '0;
        top_end   = '0;
        top_count = '0;
        top_mode  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_top[i]) begin
                top_start = start_q[i];
                top_end   = end_q[i];
                top_count = count_q[i];
                top_mode  = mode_q[i];
            end
        end
    end

    assign level = lvl_q;

endmodule

// File: rtl/hwl_exit_eval.sv
module hwl_exit_eval
    import hwl_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          active,
    input  logic [AW-1:0] fetch_pc,
    input  logic [AW-1:0] top_end,
    input  logic [CW-1:0] top_count,
    input  logic [1:0]    top_mode,
    input  logic          cond_flag,
    output logic          loop_back,
    output logic          loop_exit
);

    logic       at_end;
    logic       cond_hit;
    term_mode_t mode;

    assign mode   = term_mode_t'(top_mode);
    assign at_end = active && (fetch_pc == top_end);

    always_comb begin
        unique case (mode)
            TM_UNTIL_HI:  cond_hit = cond_flag;
            TM_UNTIL_LO:  cond_hit = !cond_flag;
            TM_COUNT,
            TM_COUNT_ALT: cond_hit = 1'b0;
            default:      cond_hit = 1'b0;
        endcase
    end

    assign loop_back = at_end && (top_count > CW'(1)) && !cond_hit;
    assign loop_exit = at_end && !loop_back;

endmodule

// File: rtl/hwl_ctrl.sv
module hwl_ctrl
    import hwl_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          setup_valid,
    input  logic          count_zero,
    input  logic          loop_back,
    input  logic          loop_exit,
    input  logic [LW-1:0] level,
    output seq_state_t    state,
    output logic          push,
    output logic          pop,
    output logic          dec,
    output logic          skip,
    output logic          overflow
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       ovf_q;
    logic       ovf_set;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ovf_set) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // Outputs: stack operations and redirect selection.
    always_comb begin
        push    = 1'b0;
        pop     = 1'b0;
        dec     = 1'b0;
        skip    = 1'b0;
        ovf_set = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                skip = setup_valid && count_zero;
                push = setup_valid && !count_zero;
            end
            ST_LOOPING: begin
                skip = setup_valid && count_zero;
                push = setup_valid && !count_zero;
                dec  = !setup_valid && loop_back;
                pop  = !setup_valid && loop_exit;
            end
            ST_FULL: begin
                skip    = setup_valid && count_zero;
                ovf_set = setup_valid && !count_zero;
                dec     = !setup_valid && loop_back;
                pop     = !setup_valid && loop_exit;
            end
            default: begin
                skip = 1'b0;
            end
        endcase
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) state_d = ST_LOOPING;
            end
            ST_LOOPING: begin
                if (push && level == LW'(DEPTH - 1)) state_d = ST_FULL;
                else if (pop && level == LW'(1))     state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (pop) state_d = ST_LOOPING;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign state    = state_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
    import hwl_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          setup_valid,
    input  logic [AW-1:0] setup_start,
    input  logic [AW-1:0] setup_end,
    input  logic [CW-1:0] setup_count,
    input  logic [1:0]    setup_mode,
    input  logic [AW-1:0] fetch_pc,
    input  logic          cond_flag,
    output logic [AW-1:0] next_pc,
    output logic          next_pc_override,
    output logic          loop_active,
    output logic [LW-1:0] loop_level,
    output logic [CW-1:0] loop_remaining,
    output logic          overflow_err
);

    logic [AW-1:0] top_start;
    logic [AW-1:0] top_end;
    logic [CW-1:0] top_count;
    logic [1:0]    top_mode;
    logic [LW-1:0] level;
    logic          do_push;
    logic          do_pop;
    logic          do_dec;
    logic          do_skip;
    logic          loop_back;
    logic          loop_exit;
    seq_state_t    fsm_state;

    hwl_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .LW(LW)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (do_push),
        .pop        (do_pop),
        .dec        (do_dec),
        .push_start (setup_start),
        .push_end   (setup_end),
        .push_count (setup_count),
        .push_mode  (setup_mode),
        .level      (level),
        .top_start  (top_start),
        .top_end    (top_end),
        .top_count  (top_count),
        .top_mode   (top_mode)
    );

    hwl_exit_eval #(.AW(AW), .CW(CW)) u_eval (
        .active    (level != '0),
        .fetch_pc  (fetch_pc),
        .top_end   (top_end),
        .top_count (top_count),
        .top_mode  (top_mode),
        .cond_flag (cond_flag),
        .loop_back (loop_back),
        .loop_exit (loop_exit)
    );

    hwl_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_valid (setup_valid),
        .count_zero  (setup_count == '0),
        .loop_back   (loop_back),
        .loop_exit   (loop_exit),
        .level       (level),
        .state       (fsm_state),
        .push        (do_push),
        .pop         (do_pop),
        .dec         (do_dec),
        .skip        (do_skip),
        .overflow    (overflow_err)
    );

    // Next-PC selection: skip over a zero-count body, loop back, or fall through.
    always_comb begin
        if (do_skip) begin
            next_pc          = setup_end + AW'(1);
            next_pc_override = 1'b1;
        end else if (do_dec) begin
            next_pc          = top_start;
            next_pc_override = 1'b1;
        end else begin
            next_pc          = fetch_pc + AW'(1);
            next_pc_override = 1'b0;
        end
    end

    assign loop_active    = (level != '0);
    assign loop_level     = level;
    assign loop_remaining = top_count;

endmodule

// File: rtl/hwloop_seq_chk.sv
module hwloop_seq_chk
    import hwl_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    parameter int LW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          setup_valid,
    input logic [AW-1:0] setup_end,
    input logic [CW-1:0] setup_count,
    input logic [AW-1:0] fetch_pc,
    input logic [AW-1:0] next_pc,
    input logic          next_pc_override,
    input logic          loop_active,
    input logic [LW-1:0] loop_level,
    input logic [CW-1:0] loop_remaining,
    input logic          overflow_err,
    input seq_state_t    fsm_state
);

    // R1: reset clears the stack and the error flag
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (loop_level == '0 && !overflow_err));

    // R3: a loop-back override only happens with a loop held
    a_r3_back_needs_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (next_pc_override && !setup_valid) |-> loop_active);

    // R4: count drops by one after a loop-back
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (next_pc_override && !setup_valid) |=> loop_remaining == $past(loop_remaining) - CW'(1));

    // R7: zero count skips to end+1 and leaves the stack alone
    a_r7_skip_target: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && setup_count == '0) |-> (next_pc_override && next_pc == setup_end + AW'(1)));

    a_r7_skip_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && setup_count == '0) |=> $stable(loop_level));

    // R8: error is sticky, full stack refuses pushes
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_level == LW'(DEPTH) && setup_valid) |=> loop_level == LW'(DEPTH));

    // R11: without override fetch proceeds sequentially
    a_r11_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        !next_pc_override |-> next_pc == fetch_pc + AW'(1));

    // R2 / R8: state machine agrees with the stack pointer
    a_r2_state_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_EMPTY) == (loop_level == '0));

    a_r8_state_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_FULL) == (loop_level == LW'(DEPTH)));

endmodule

bind hwloop_seq hwloop_seq_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .setup_valid      (setup_valid),
    .setup_end        (setup_end),
    .setup_count      (setup_count),
    .fetch_pc         (fetch_pc),
    .next_pc          (next_pc),
    .next_pc_override (next_pc_override),
    .loop_active      (loop_active),
    .loop_level       (loop_level),
    .loop_remaining   (loop_remaining),
    .overflow_err     (overflow_err),
    .fsm_state        (fsm_state)
);

// File: tb/sim_hwloop_seq.sv
module sim_hwloop_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0;
    logic [15:0] setup_start = '0;
    logic [15:0] setup_end = '0;
    logic [15:0] setup_count = '0;
    logic [1:0]  setup_mode = '0;
    logic [15:0] fetch_pc = '0;
    logic        cond_flag = 1'b0;
    logic [15:0] next_pc;
    logic        next_pc_override;
    logic        loop_active;
    logic [2:0]  loop_level;
    logic [15:0] loop_remaining;
    logic        overflow_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of the loop stack
    logic [15:0] m_st [DEPTH];
    logic [15:0] m_en [DEPTH];
    logic [15:0] m_ct [DEPTH];
    logic [1:0]  m_md [DEPTH];
    int          m_lv = 0;
    bit          m_ovf = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hwloop_seq u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .setup_valid      (setup_valid),
        .setup_start      (setup_start),
        .setup_end        (setup_end),
        .setup_count      (setup_count),
        .setup_mode       (setup_mode),
        .fetch_pc         (fetch_pc),
        .cond_flag        (cond_flag),
        .next_pc          (next_pc),
        .next_pc_override (next_pc_override),
        .loop_active      (loop_active),
        .loop_level       (loop_level),
        .loop_remaining   (loop_remaining),
        .overflow_err     (overflow_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cond_exit(input logic [1:0] md, input logic cf);
        return (md == 2'd1 && cf) || (md == 2'd2 && !cf);
    endfunction

    function automatic logic [15:0] exp_remaining();
        return (m_lv > 0) ? m_ct[m_lv-1] : 16'd0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        setup_valid = 1'b0;
        setup_count = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_lv = 0;
        m_ovf = 1'b0;
    endtask

    // One cycle: drive, check same-cycle outputs, clock, check registered state.
    task automatic step(input logic sv, input logic [15:0] s, input logic [15:0] e,
                        input logic [15:0] c, input logic [1:0] m,
                        input logic [15:0] pc, input logic cf);
        bit          at_end;
        bit          hit;
        bit          back;
        logic        e_ovr;
        logic [15:0] e_npc;
        string       t;
        @(negedge clk);
        setup_valid = sv; setup_start = s; setup_end = e;
        setup_count = c; setup_mode = m; fetch_pc = pc; cond_flag = cf;
        at_end = (m_lv > 0) && (pc == m_en[m_lv-1]);
        hit    = at_end && cond_exit(m_md[m_lv-1], cf);
        back   = at_end && !hit && (m_ct[m_lv-1] > 16'd1);
        if (sv && c == 16'd0) begin
            e_ovr = 1'b1; e_npc = e + 16'd1; t = "R7";
        end else if (sv) begin
            e_ovr = 1'b0; e_npc = pc + 16'd1; t = at_end ? "R10" : "R2";
        end else if (back) begin
            e_ovr = 1'b1; e_npc = m_st[m_lv-1]; t = "R3";
        end else if (at_end) begin
            e_ovr = 1'b0; e_npc = pc + 16'd1; t = hit ? "R6" : "R5";
        end else begin
            e_ovr = 1'b0; e_npc = pc + 16'd1; t = "R11";
        end
        #1;
        chk(t, {31'd0, next_pc_override}, {31'd0, e_ovr});
        chk(t, {16'd0, next_pc}, {16'd0, e_npc});
        @(posedge clk);
        if (sv) begin
            if (c != 16'd0) begin
                if (m_lv < DEPTH) begin
                    m_st[m_lv] = s; m_en[m_lv] = e; m_ct[m_lv] = c; m_md[m_lv] = m;
                    m_lv++;
                end else begin
                    m_ovf = 1'b1;
                end
            end
        end else if (back) begin
            m_ct[m_lv-1] = m_ct[m_lv-1] - 16'd1;
        end else if (at_end) begin
            m_lv--;
        end
        #1;
        chk("R2", {29'd0, loop_level}, m_lv);
        chk("R4", {16'd0, loop_remaining}, {16'd0, exp_remaining()});
        chk("R8", {31'd0, overflow_err}, {31'd0, m_ovf});
    endtask

    task automatic idle(input logic [15:0] pc);
        step(1'b0, 16'd0, 16'd0, 16'd0, 2'd0, pc, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: reset state
        fetch_pc = 16'd5;
        #1;
        chk("R1", {29'd0, loop_level}, 32'd0);
        chk("R1", {31'd0, loop_active}, 32'd0);
        chk("R1", {31'd0, overflow_err}, 32'd0);
        chk("R1", {16'd0, loop_remaining}, 32'd0);
        chk("R1", {31'd0, next_pc_override}, 32'd0);

        // R3/R4/R5: three iterations over 11..13
        step(1'b1, 16'd11, 16'd13, 16'd3, 2'd0, 16'd10, 1'b0);
        for (int it = 0; it < 3; it++) begin
            idle(16'd11); idle(16'd12); idle(16'd13);
        end
        chk("R5", {29'd0, loop_level}, 32'd0);

        // R7: zero count skips
        step(1'b1, 16'd31, 16'd40, 16'd0, 2'd0, 16'd30, 1'b0);

        // R6: mode 1 exits on cond high, mode 2 on cond low, mode 3 counts
        step(1'b1, 16'd20, 16'd22, 16'd5, 2'd1, 16'd19, 1'b0);
        idle(16'd22);
        step(1'b0, 16'd0, 16'd0, 16'd0, 2'd0, 16'd22, 1'b1);
        chk("R6", {29'd0, loop_level}, 32'd0);
        step(1'b1, 16'd25, 16'd30, 16'd5, 2'd2, 16'd24, 1'b0);
        step(1'b0, 16'd0, 16'd0, 16'd0, 2'd0, 16'd30, 1'b0);
        chk("R6", {29'd0, loop_level}, 32'd0);
        step(1'b1, 16'd25, 16'd30, 16'd2, 2'd3, 16'd24, 1'b0);
        step(1'b0, 16'd0, 16'd0, 16'd0, 2'd0, 16'd30, 1'b0);
        chk("R6", {31'd0, next_pc_override}, 32'd0);
        chk("R6", {16'd0, loop_remaining}, 32'd1);
        step(1'b0, 16'd0, 16'd0, 16'd0, 2'd0, 16'd30, 1'b1);

        // R9: nesting
        step(1'b1, 16'd100, 16'd110, 16'd2, 2'd0, 16'd99, 1'b0);
        step(1'b1, 16'd102, 16'd104, 16'd2, 2'd0, 16'd101, 1'b0);
        idle(16'd104);
        idle(16'd110);
        chk("R9", {29'd0, loop_level}, 32'd2);
        idle(16'd104);
        chk("R9", {16'd0, loop_remaining}, 32'd2);
        idle(16'd110);
        idle(16'd110);

        // R10: setup wins over an end match
        step(1'b1, 16'd45, 16'd50, 16'd3, 2'd0, 16'd44, 1'b0);
        step(1'b1, 16'd60, 16'd70, 16'd2, 2'd0, 16'd50, 1'b0);
        chk("R10", {16'd0, loop_remaining}, 32'd2);
        chk("R10", {29'd0, loop_level}, 32'd2);

        // R8: fill the stack, then overflow
        step(1'b1, 16'd80, 16'd81, 16'd7, 2'd0, 16'd79, 1'b0);
        step(1'b1, 16'd82, 16'd83, 16'd9, 2'd0, 16'd81, 1'b0);
        step(1'b1, 16'd84, 16'd85, 16'd4, 2'd0, 16'd83, 1'b0);
        chk("R8", {29'd0, loop_level}, 32'd4);
        chk("R8", {31'd0, overflow_err}, 32'd1);
        chk("R8", {16'd0, loop_remaining}, 32'd9);
        idle(16'd3);
        chk("R8", {31'd0, overflow_err}, 32'd1);

        // Random mix against the model
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            logic        sv;
            logic [15:0] s;
            logic [15:0] pc;
            sv = ($urandom % 6) == 0;
            s  = 16'($urandom % 64);
            if (m_lv > 0 && ($urandom % 2) == 0) pc = m_en[m_lv-1];
            else                                 pc = 16'($urandom % 80);
            step(sv, s, s + 16'(1 + $urandom % 8), 16'($urandom % 4),
                 2'($urandom % 4), pc, 1'($urandom % 2));
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule